// File: doc/BRIEF.md
# Coded Reference Frequency Divider

This block divides a reference clock down to the phase comparison rate of a frequency synthesiser loop. Each divided period ends with a single-cycle pulse on `fcomp`. The ratio is chosen by a 5-bit code. The upper two bits pick a base value of 2, 5, 3 or 7. The lower three bits (`k`) scale that base by a power of two. Some codes are odd, so the divider has to produce exact odd periods as well as even ones.

A new code is presented on `ratio_code` and qualified by a one-cycle `code_valid` strobe. Legal codes are held as the pending ratio. The running period always completes before the pending ratio takes effect, so no period is ever cut short. Three codes are reserved. When one of them is strobed, the block raises `code_illegal` and keeps dividing by the last legal ratio. The `fcomp` pulse is suitable for routing to a test port.

Top module: `fcomp_divider`

## Requirements
- R1: After reset the ratio is that of code 5'b00000, so `fcomp` pulses every 2 reference cycles.
- R2: Codes with bits [4:3] = 2'b00 divide by 2^(k+1), where k = bits [2:0] (ratios 2 to 256).
- R3: Codes with bits [4:3] = 2'b01 and k from 1 to 7 divide by 5·2^(k−1) (ratios 5 to 320).
- R4: Codes with bits [4:3] = 2'b10 and k from 1 to 7 divide by 3·2^k (ratios 6 to 384).
- R5: Codes with bits [4:3] = 2'b11 and k from 1 to 7 divide by 7·2^(k−1) (ratios 7 to 448).
- R6: A strobed code with k = 0 and bits [4:3] not 2'b00 is illegal. `code_illegal` is 1 from the cycle after the strobe, and the ratio stays at the last legal value.
- R7: A strobed legal code drives `code_illegal` to 0 from the cycle after the strobe.
- R8: A new ratio takes effect only at a terminal count. The period running when the code is strobed completes with the old ratio.
- R9: `fcomp` is high for exactly one reference cycle per period and never on two cycles in a row.
- R10: `code_illegal` changes only in the cycle after a `code_valid` strobe.
- R11: While reset is asserted, `fcomp` and `code_illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ratio_code | input | 5 | Ratio code: [4:3] base family, [2:0] power-of-two scale k |
| code_valid | input | 1 | One-cycle strobe that qualifies `ratio_code` |
| fcomp | output | 1 | Single-cycle pulse at the end of each divided period |
| code_illegal | output | 1 | High after a reserved code was strobed |

## Verification
All 32 codes are strobed in turn, so every legal ratio in each of the four families is measured over two full periods. This separates off-by-one errors in the power-of-two scale from a wrong base in a family. The three reserved codes fall between legal ones, which shows that the flag is raised and the previous ratio survives. Each strobe is followed by a measurement of the period already running. That measurement tells a correct terminal-count reload apart from an immediate reload that would shorten it.

// File: rtl/fcomp_divider_pkg.sv
package fcomp_divider_pkg;

  localparam int CODE_W = 5;
  localparam int K_W    = 3;
  localparam int SH_W   = 4;

  typedef enum logic [1:0] {
    FAM_POW2  = 2'b00,
    FAM_FIVE  = 2'b01,
    FAM_THREE = 2'b10,
    FAM_SEVEN = 2'b11
  } ratio_family_e;

endpackage

// File: rtl/fcomp_reset_sync.sv
module fcomp_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/fcomp_ratio_decode.sv
module fcomp_ratio_decode
  import fcomp_divider_pkg::*;
#(
  parameter int RATIO_W = 9
) (
  input  logic [CODE_W-1:0]  code,
  output logic [RATIO_W-1:0] ratio,
  output logic               legal
);

  ratio_family_e      fam;
  logic [K_W-1:0]     k;
  logic [RATIO_W-1:0] base;
  logic [SH_W-1:0]    sh;

  always_comb begin
    fam  = ratio_family_e'(code[4:3]);
    k    = code[K_W-1:0];
    base = RATIO_W'(1);
    sh   = '0;
    unique case (fam)
      FAM_POW2: begin
        base = RATIO_W'(1);
        sh   = SH_W'(k) + SH_W'(1);
      end
      FAM_FIVE: begin
        base = RATIO_W'(5);
        sh   = SH_W'(k) - SH_W'(1);
      end
      FAM_THREE: begin
        base = RATIO_W'(3);
        sh   = SH_W'(k);
      end
      FAM_SEVEN: begin
        base = RATIO_W'(7);
        sh   = SH_W'(k) - SH_W'(1);
      end
      default: begin
        base = RATIO_W'(1);
        sh   = '0;
      end
    endcase
    legal = (fam == FAM_POW2) || (k != '0);
    ratio = legal ? (base << sh) : '0;
  end

endmodule

// File: rtl/fcomp_ratio_hold.sv
module fcomp_ratio_hold #(
  parameter int RATIO_W     = 9,
  parameter int RESET_RATIO = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               code_valid,
  input  logic [RATIO_W-1:0] dec_ratio,
  input  logic               dec_legal,
  output logic [RATIO_W-1:0] pending_ratio,
  output logic               illegal
);

  logic [RATIO_W-1:0] pending_q, pending_d;
  logic               illegal_q, illegal_d;
  logic               pending_en, illegal_en;

  always_comb begin
    pending_en = code_valid && dec_legal;
    illegal_en = code_valid;
    pending_d  = dec_ratio;
    illegal_d  = !dec_legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= RATIO_W'(RESET_RATIO);
    end else if (pending_en) begin
      pending_q <= pending_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      illegal_q <= 1'b0;
    end else if (illegal_en) begin
      illegal_q <= illegal_d;
    end
  end

  assign pending_ratio = pending_q;
  assign illegal       = illegal_q;

endmodule

// File: rtl/fcomp_period_counter.sv
module fcomp_period_counter #(
  parameter int RATIO_W     = 9,
  parameter int RESET_RATIO = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] reload_ratio,
  output logic               terminal,
  output logic [RATIO_W-1:0] count
);

  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic               at_end;

  always_comb begin
    at_end = (cnt_q == '0);
    if (at_end) cnt_d = reload_ratio - RATIO_W'(1);
    else        cnt_d = cnt_q - RATIO_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RATIO_W'(RESET_RATIO - 1);
    else        cnt_q <= cnt_d;
  end

  assign terminal = at_end;
  assign count    = cnt_q;

endmodule

// File: rtl/fcomp_divider.sv
module fcomp_divider
  import fcomp_divider_pkg::*;
#(
  parameter int RATIO_W     = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic              code_valid,
  output logic              fcomp,
  output logic              code_illegal
);

  localparam int RESET_RATIO = 2;

  logic               rst_n_sync;
  logic [RATIO_W-1:0] dec_ratio;
  logic               dec_legal;
  logic [RATIO_W-1:0] pending_ratio;
  logic [RATIO_W-1:0] count_now;
  logic               terminal;

  fcomp_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  fcomp_ratio_decode #(.RATIO_W(RATIO_W)) u_dec (
    .code  (ratio_code),
    .ratio (dec_ratio),
    .legal (dec_legal)
  );

  fcomp_ratio_hold #(.RATIO_W(RATIO_W), .RESET_RATIO(RESET_RATIO)) u_hold (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .code_valid    (code_valid),
    .dec_ratio     (dec_ratio),
    .dec_legal     (dec_legal),
    .pending_ratio (pending_ratio),
    .illegal       (code_illegal)
  );

  fcomp_period_counter #(.RATIO_W(RATIO_W), .RESET_RATIO(RESET_RATIO)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .reload_ratio (pending_ratio),
    .terminal     (terminal),
    .count        (count_now)
  );

  assign fcomp = terminal && rst_n_sync;

endmodule

// File: rtl/fcomp_divider_checker.sv
module fcomp_divider_checker #(
  parameter int RATIO_W = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic [4:0]         ratio_code,
  input logic               code_valid,
  input logic               fcomp,
  input logic               code_illegal,
  input logic [RATIO_W-1:0] pending_ratio,
  input logic [RATIO_W-1:0] count_now
);

  logic code_bad;
  assign code_bad = (ratio_code[2:0] == 3'd0) && (ratio_code[4:3] != 2'b00);

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fcomp |=> !fcomp);

  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !code_valid |=> $stable(code_illegal));

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && code_bad) |=> code_illegal);

  p_ratio_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && code_bad) |=> $stable(pending_ratio));

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && !code_bad) |=> !code_illegal);

  p_no_early_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fcomp |=> (count_now == $past(count_now) - RATIO_W'(1)));

  p_ratio_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_ratio >= RATIO_W'(2)) && (pending_ratio <= RATIO_W'(448)));

endmodule

bind fcomp_divider fcomp_divider_checker #(.RATIO_W(RATIO_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n_sync),
  .ratio_code    (ratio_code),
  .code_valid    (code_valid),
  .fcomp         (fcomp),
  .code_illegal  (code_illegal),
  .pending_ratio (pending_ratio),
  .count_now     (count_now)
);

// File: tb/fcomp_divider_bench.sv
module fcomp_divider_bench;

  localparam int CLK_NS = 4;

  logic       clk;
  logic       rst_n;
  logic [4:0] code;
  logic       code_valid;
  logic       fcomp;
  logic       illegal;

  int    checks;
  int    errors;
  int    exp_q[$];
  string tag_q[$];
  bit    done;
  bit    exp_flag;
  int    cur_ratio;

  int cyc;
  int last_pulse;
  bit prev_f;
  bit seen;
  int got;
  int want;
  string tg;

  fcomp_divider u_fcomp_divider (
    .clk          (clk),
    .rst_n        (rst_n),
    .ratio_code   (code),
    .code_valid   (code_valid),
    .fcomp        (fcomp),
    .code_illegal (illegal)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  function automatic bit model_legal(input logic [4:0] c);
    return (c[4:3] == 2'b00) || (c[2:0] != 3'd0);
  endfunction

  function automatic int model_ratio(input logic [4:0] c);
    int k;
    k = int'(c[2:0]);
    case (c[4:3])
      2'b00:   return 2 << k;
      2'b01:   return 5 << (k - 1);
      2'b10:   return 3 << k;
      default: return 7 << (k - 1);
    endcase
  endfunction

  function automatic string family_tag(input logic [4:0] c);
    if (!model_legal(c)) return "R6";
    case (c[4:3])
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  // monitor: measures periods, pops expected values, checks width and flag
  always @(negedge clk) begin
    cyc++;
    if (fcomp && prev_f) begin
      checks++; errors++;
      $display("FAIL R9: fcomp high two cycles running at cycle %0d (got 1, expected 0)", cyc);
    end
    if (fcomp) begin
      if (seen && exp_q.size() > 0) begin
        want = exp_q.pop_front();
        tg   = tag_q.pop_front();
        got  = cyc - last_pulse;
        checks++;
        if (got != want) begin
          errors++;
          $display("FAIL %s: period %0d, expected %0d", tg, got, want);
        end
        checks++;
        if (illegal !== exp_flag) begin
          errors++;
          $display("FAIL R10: flag between strobes %0b, expected %0b", illegal, exp_flag);
        end
      end
      seen       = 1'b1;
      last_pulse = cyc;
    end
    prev_f = fcomp;
  end

  task automatic wait_pulses(input int n);
    repeat (n) begin
      @(negedge clk);
      while (!fcomp) @(negedge clk);
    end
  endtask

  // driver: strobe a code at a pulse, then queue the expected periods
  task automatic run_code(input logic [4:0] c, input int nper);
    int old_ratio;
    bit ok;
    old_ratio  = cur_ratio;
    ok         = model_legal(c);
    code       = c;
    code_valid = 1'b1;
    @(negedge clk);
    code_valid = 1'b0;
    checks++;
    if (illegal !== !ok) begin
      errors++;
      $display("FAIL %s: flag after code %05b is %0b, expected %0b",
               ok ? "R7" : "R6", c, illegal, !ok);
    end
    exp_flag = !ok;
    if (ok) cur_ratio = model_ratio(c);
    exp_q.push_back(old_ratio);
    tag_q.push_back("R8");
    repeat (nper) begin
      exp_q.push_back(cur_ratio);
      tag_q.push_back(family_tag(c));
    end
    wait_pulses(nper + 1);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete (got timeout, expected finish)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0; exp_flag = 1'b0; cur_ratio = 2;
    cyc = 0; last_pulse = 0; prev_f = 1'b0; seen = 1'b0;
    rst_n = 1'b0; code = 5'd0; code_valid = 1'b0;
    repeat (4) begin
      @(negedge clk);
      checks++;
      if (fcomp !== 1'b0 || illegal !== 1'b0) begin
        errors++;
        $display("FAIL R11: in reset fcomp=%0b flag=%0b, expected 0 and 0", fcomp, illegal);
      end
    end
    rst_n = 1'b1;
    wait_pulses(1);
    @(negedge clk);
    repeat (3) begin
      exp_q.push_back(2);
      tag_q.push_back("R1");
    end
    wait_pulses(3);
    for (int i = 0; i < 32; i++) begin
      run_code(5'(i), 2);
    end
    run_code(5'b11010, 2);
    run_code(5'b01000, 2);
    run_code(5'b00000, 3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule